// File: doc/BRIEF.md
# Variable-Length DMA Bus Cycle Sequencer

This block produces the bus strobes for one read or write transfer of a DMA engine on a bus that shares memory and I/O cycles. A one-cycle `start` pulse launches a transfer. On that edge the block latches the port type, the direction, the timing mode, the programmed length and the early-end enables. It then steps through T-states and drives active-low I/O-request, memory-request, read and write strobes. It raises `done` for one clock after the last T-state. Any half-cycle timing comes from a small set of falling-edge registers kept inside the block.

There are two timing modes. In fixed mode a transfer is always three T-states long and every strobe it uses goes active together in T1. In variable mode the length is programmable. The I/O-request strobe leads the others by one T-state. A wait input can stretch certain lengths by whole wait states. Read data is captured at the edge that ends the read strobe and is then held for the engine's following write.

The controller has six states. ST_IDLE goes to ST_T1 on `start`. ST_T1 goes to ST_T2. ST_T2 and ST_T3 each go back to ST_IDLE when they are the final state of the transfer. When they are the wait-sampling state and a wait was sampled, they go to ST_TW. Otherwise they step on to the next T-state. ST_T4 always returns to ST_IDLE. ST_TW stays in ST_TW while wait is still sampled and otherwise moves on to the state after the sampling state.

Top module: `dma_cycle_seq`

## Requirements
- R1: While reset is asserted and afterwards until a start, all four strobes are high, `done` and `data_lat` are low, and `data_out` is zero.
- R2: With `var_mode`=0 every transfer lasts exactly 3 T-states whatever `len_sel` is. The strobes it uses go low together at the start of T1 and go high at the rising edge that ends T3.
- R3: With `var_mode`=1 on an I/O transfer, `iorq_n` goes low at the start of T1. `rd_n` or `wr_n` goes low one T-state later, at the start of T2.
- R4: With `var_mode`=1, `len_sel` sets the length: 0 gives 2 T-states, 1 gives 3, and 2 or 3 give 4. `mreq_n`, `rd_n` and `wr_n` go low at the start of T2.
- R5: On variable memory transfers of 3 or 4 T-states, `wait_n` is sampled on the falling edge within T2. Each low sample adds one whole wait state after the sampling state, with the strobes held. The wait state samples `wait_n` again on its own falling edge.
- R6: On variable I/O transfers of 4 T-states, `wait_n` is sampled the same way on the falling edge within T3.
- R7: `wait_n` has no effect in fixed mode, on 2-state variable memory transfers, or on 2- and 3-state variable I/O transfers.
- R8: `early_end` bit 3 (I/O request), bit 2 (memory request), bit 1 (read) and bit 0 (write) each move the deasserting edge of their own strobe to the falling edge within the final T-state, independently of the other bits.
- R9: On a read, `data_in` is captured at the edge where `rd_n` rises. The captured value appears on `data_out` at the rising edge that ends the transfer, with a one-cycle `data_lat` pulse. On writes `data_out` is held unchanged.
- R10: `done` is high for exactly one clock, starting at the rising edge that ends the final T-state. A `start` pulse that arrives while a transfer is running is ignored.
- R11: Only the strobes that match the transfer go low: `port_io`=1 selects `iorq_n` and `port_io`=0 selects `mreq_n`; `dir_wr`=0 selects `rd_n` and `dir_wr`=1 selects `wr_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; T-states begin on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transfer |
| port_io | input | 1 | 1 = I/O transfer, 0 = memory transfer |
| dir_wr | input | 1 | 1 = write, 0 = read |
| var_mode | input | 1 | 1 = variable timing, 0 = fixed 3-state timing |
| len_sel | input | 2 | Variable length: 0 = 2, 1 = 3, 2/3 = 4 T-states |
| early_end | input | 4 | Early trailing edge enables {IORQ, MREQ, RD, WR} |
| wait_n | input | 1 | Active-low wait request |
| data_in | input | DATA_W | Read data from the bus |
| iorq_n | output | 1 | Active-low I/O request strobe |
| mreq_n | output | 1 | Active-low memory request strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| data_out | output | DATA_W | Captured read data, held across writes |
| data_lat | output | 1 | One-cycle pulse when new read data is presented |
| done | output | 1 | One-cycle transfer-complete pulse |

## Verification
Directed transfers cover both timing modes, every length encoding, both port types and both directions. The bench samples the strobes in each half of every T-state, so it can tell a strobe that leads by one state from one that asserts together with the others. Wait bursts of one to three low samples are sent both to honoured lengths and to ignored lengths, so a wrong sampling state or a wrong length filter changes the transfer length that the bench sees. Early-end masks that cut only some of the strobes of a transfer show that each enable acts alone. A write that follows a read, and a start pulse sent during a running transfer, check that read data is held and that the extra request is dropped.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_T4,
        ST_TW
    } seq_state_e;

    localparam int NSTB   = 4;
    localparam int STB_IO = 3;
    localparam int STB_MR = 2;
    localparam int STB_RD = 1;
    localparam int STB_WR = 0;

    typedef struct packed {
        logic            io;
        logic            wr;
        logic            vmode;
        logic [1:0]      len;
        logic [NSTB-1:0] early;
    } seq_cfg_t;
endpackage

// File: rtl/dma_seq_fsm.sv
`timescale 1ns/1ps
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  seq_cfg_t        cfg_in,
    input  logic            wait_hit,
    output seq_state_e      state_q,
    output seq_cfg_t        cfg_q,
    output logic            final_now,
    output logic            samp_now,
    output logic            honour,
    output logic            done_q,
    output logic [NSTB-1:0] act
);
    seq_state_e last_st, samp_st, resume_st, state_d;
    logic busy, lead;

    // Length decode, wait-sampling point and next-state logic
    always_comb begin
        if (!cfg_q.vmode) begin
            last_st = ST_T3;
        end else begin
            unique case (cfg_q.len)
                2'd0:    last_st = ST_T2;
                2'd1:    last_st = ST_T3;
                default: last_st = ST_T4;
            endcase
        end
        honour    = cfg_q.vmode && (cfg_q.io ? (cfg_q.len >= 2'd2) : (cfg_q.len != 2'd0));
        samp_st   = cfg_q.io ? ST_T3 : ST_T2;
        resume_st = cfg_q.io ? ST_T4 : ST_T3;
        final_now = (state_q == last_st);
        samp_now  = ((state_q == samp_st) && honour) || (state_q == ST_TW);

        unique case (state_q)
            ST_IDLE: state_d = start ? ST_T1 : ST_IDLE;
            ST_T1:   state_d = ST_T2;
            ST_T2: begin
                if (final_now)                 state_d = ST_IDLE;
                else if (samp_now && wait_hit) state_d = ST_TW;
                else                           state_d = ST_T3;
            end
            ST_T3: begin
                if (final_now)                 state_d = ST_IDLE;
                else if (samp_now && wait_hit) state_d = ST_TW;
                else                           state_d = ST_T4;
            end
            ST_T4:   state_d = ST_IDLE;
            ST_TW:   state_d = wait_hit ? ST_TW : resume_st;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register, latched transfer settings, done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) cfg_q <= cfg_in;
            done_q  <= final_now;
        end
    end

    // Rising-edge strobe enables per state
    always_comb begin
        busy        = (state_q != ST_IDLE);
        lead        = busy && (!cfg_q.vmode || state_q != ST_T1);
        act[STB_IO] = busy && cfg_q.io;
        act[STB_MR] = lead && !cfg_q.io;
        act[STB_RD] = lead && !cfg_q.wr;
        act[STB_WR] = lead && cfg_q.wr;
    end

    a_r10_t1_only_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T1) |-> ($past(state_q) == ST_IDLE));

    a_r7_wait_only_when_honoured: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TW) |-> honour);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    a_r2_fixed_three_states: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T4) |-> cfg_q.vmode);
endmodule

// File: rtl/dma_seq_half.sv
`timescale 1ns/1ps
module dma_seq_half
    import dma_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            samp_now,
    input  logic            final_now,
    input  logic            wait_n,
    input  logic [NSTB-1:0] early,
    input  logic [NSTB-1:0] act,
    output logic            wait_hit,
    output logic [NSTB-1:0] stb_n
);
    logic [NSTB-1:0] cut_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) wait_hit <= 1'b0;
        else        wait_hit <= samp_now && !wait_n;
    end

    for (genvar i = 0; i < NSTB; i++) begin : g_stb
        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) cut_q[i] <= 1'b0;
            else        cut_q[i] <= final_now && early[i];
        end
        assign stb_n[i] = !(act[i] && !cut_q[i]);
    end

    a_r8_cut_only_in_final: assert property (@(posedge clk) disable iff (!rst_n)
        (|cut_q) |-> final_now);
endmodule

// File: rtl/dma_seq_cap.sv
`timescale 1ns/1ps
module dma_seq_cap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              final_now,
    input  logic              is_read,
    input  logic              rd_early,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_lat
);
    logic [DATA_W-1:0] half_cap;

    // Read strobe ends on the falling edge when cut early
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)                                   half_cap <= '0;
        else if (final_now && is_read && rd_early)    half_cap <= data_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_out <= '0;
            data_lat <= 1'b0;
        end else begin
            data_lat <= final_now && is_read;
            if (final_now && is_read)
                data_out <= rd_early ? half_cap : data_in;
        end
    end

    a_r9_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_out) |-> data_lat);
endmodule

// File: rtl/dma_cycle_seq.sv
`timescale 1ns/1ps
module dma_cycle_seq
    import dma_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              port_io,
    input  logic              dir_wr,
    input  logic              var_mode,
    input  logic [1:0]        len_sel,
    input  logic [3:0]        early_end,
    input  logic              wait_n,
    input  logic [DATA_W-1:0] data_in,
    output logic              iorq_n,
    output logic              mreq_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] data_out,
    output logic              data_lat,
    output logic              done
);
    seq_cfg_t        cfg_in, cfg_q;
    seq_state_e      state_q;
    logic            final_now, samp_now, honour, wait_hit;
    logic [NSTB-1:0] act, stb_n;

    always_comb begin
        cfg_in.io    = port_io;
        cfg_in.wr    = dir_wr;
        cfg_in.vmode = var_mode;
        cfg_in.len   = len_sel;
        cfg_in.early = early_end;
    end

    dma_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cfg_in   (cfg_in),
        .wait_hit (wait_hit),
        .state_q  (state_q),
        .cfg_q    (cfg_q),
        .final_now(final_now),
        .samp_now (samp_now),
        .honour   (honour),
        .done_q   (done),
        .act      (act)
    );

    dma_seq_half u_half (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp_now (samp_now),
        .final_now(final_now),
        .wait_n   (wait_n),
        .early    (cfg_q.early),
        .act      (act),
        .wait_hit (wait_hit),
        .stb_n    (stb_n)
    );

    dma_seq_cap #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .final_now(final_now),
        .is_read  (!cfg_q.wr),
        .rd_early (cfg_q.early[STB_RD]),
        .data_in  (data_in),
        .data_out (data_out),
        .data_lat (data_lat)
    );

    assign iorq_n = stb_n[STB_IO];
    assign mreq_n = stb_n[STB_MR];
    assign rd_n   = stb_n[STB_RD];
    assign wr_n   = stb_n[STB_WR];

    a_r11_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!rd_n, !wr_n}));

    a_r11_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!iorq_n, !mreq_n}));

    a_r3_io_leads: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(iorq_n) && cfg_q.vmode) |-> (rd_n && wr_n));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (iorq_n && mreq_n && rd_n && wr_n));
endmodule

// File: tb/tb_dma_cycle_seq.sv
`timescale 1ns/1ps
module tb_dma_cycle_seq;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, port_io = 1'b0, dir_wr = 1'b0, var_mode = 1'b0;
    logic [1:0]    len_sel = '0;
    logic [3:0]    early_end = '0;
    logic          wait_n = 1'b1;
    logic [DW-1:0] data_in = '0;
    logic          iorq_n, mreq_n, rd_n, wr_n, data_lat, done;
    logic [DW-1:0] data_out;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;
    logic [DW-1:0] exp_data = '0;

    always #2 clk = ~clk;

    dma_cycle_seq #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .port_io(port_io),
        .dir_wr(dir_wr), .var_mode(var_mode), .len_sel(len_sel),
        .early_end(early_end), .wait_n(wait_n), .data_in(data_in),
        .iorq_n(iorq_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
        .data_out(data_out), .data_lat(data_lat), .done(done)
    );

    task automatic check(input string req, input string what, input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act_v, exp_v, $time);
        end
    endtask

    // One transfer: drives, waits, and checks every half T-state
    task automatic run_xfer(input string req, input bit io, input bit wr, input bit vm,
                            input logic [1:0] ls, input logic [3:0] early, input int nwait,
                            input bit busy_start, input logic [DW-1:0] din);
        int  len_t, nst, first_lead, samp;
        bit  hon;
        logic [3:0] exp_v, use_v;
        len_t = !vm ? 3 : (ls == 2'd0 ? 2 : (ls == 2'd1 ? 3 : 4));
        hon   = vm && (io ? (ls >= 2'd2) : (ls != 2'd0));
        nst   = len_t + (hon ? nwait : 0);
        first_lead = vm ? 2 : 1;
        samp  = io ? 3 : 2;
        use_v = {io, !io, !wr, wr};

        @(posedge clk); #1;
        port_io = io; dir_wr = wr; var_mode = vm; len_sel = ls;
        early_end = early; data_in = din; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        port_io = ~io; dir_wr = ~wr; len_sel = ~ls; early_end = ~early;
        for (int k = 1; k <= nst + 1; k++) begin
            wait_n = !(k >= samp && k < samp + nwait);
            start  = busy_start && (k == 2);
            for (int ph = 0; ph < 2; ph++) begin
                for (int b = 0; b < 4; b++) begin
                    int first_b;
                    first_b = (b == 3) ? 1 : first_lead;
                    exp_v[b] = use_v[b] && k >= first_b && k <= nst &&
                               !(k == nst && ph == 1 && early[b]);
                end
                check(req, $sformatf("strobes T%0d phase %0d", k, ph),
                      {28'd0, ~{iorq_n, mreq_n, rd_n, wr_n}}, {28'd0, exp_v});
                if (k == nst + 1 && ph == 0) begin
                    if (!wr) exp_data = din;
                    check("R10", "done pulse", {31'd0, done}, 32'd1);
                    check("R9", "data_out", {24'd0, data_out}, {24'd0, exp_data});
                    check("R9", "data_lat", {31'd0, data_lat}, {31'd0, !wr});
                end
                if (ph == 0) begin @(negedge clk); #1; end
            end
            @(posedge clk); #1;
        end
        wait_n = 1'b1; start = 1'b0;
        data_in = ~din;
        check("R10", "done after one cycle", {31'd0, done}, 32'd0);
        check(busy_start ? "R10" : "R1", "idle strobes", {28'd0, ~{iorq_n, mreq_n, rd_n, wr_n}}, 32'd0);
        check("R9", "data held in idle", {24'd0, data_out}, {24'd0, exp_data});
    endtask

    task automatic test_reset();
        #1;
        check("R1", "strobes in reset", {28'd0, {iorq_n, mreq_n, rd_n, wr_n}}, 32'hF);
        check("R1", "done in reset", {31'd0, done}, 32'd0);
        check("R1", "data_out in reset", {24'd0, data_out}, 32'd0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R1", "strobes after reset", {28'd0, {iorq_n, mreq_n, rd_n, wr_n}}, 32'hF);
        check("R1", "data_lat after reset", {31'd0, data_lat}, 32'd0);
    endtask

    initial begin
        test_reset();
        // R2 fixed mode memory read, wait burst and len_sel ignored (R7)
        run_xfer("R2", 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000, 2, 1'b0, 8'hA5);
        // R2 fixed mode I/O write after a read: data held (R9)
        run_xfer("R2", 1'b1, 1'b1, 1'b0, 2'd3, 4'b0000, 0, 1'b0, 8'h11);
        // R3 variable I/O read, 4 states, IORQ leads
        run_xfer("R3", 1'b1, 1'b0, 1'b1, 2'd2, 4'b0000, 0, 1'b0, 8'h3C);
        // R4 variable memory write, 2 states, wait ignored (R7)
        run_xfer("R4", 1'b0, 1'b1, 1'b1, 2'd0, 4'b0000, 1, 1'b0, 8'h77);
        // R4 length encoding 3 gives 4 states
        run_xfer("R4", 1'b0, 1'b0, 1'b1, 2'd3, 4'b0000, 0, 1'b0, 8'h5A);
        // R5 memory 3 states with two wait states
        run_xfer("R5", 1'b0, 1'b0, 1'b1, 2'd1, 4'b0000, 2, 1'b0, 8'hC3);
        // R5 memory 4 states with one wait state
        run_xfer("R5", 1'b0, 1'b1, 1'b1, 2'd2, 4'b0000, 1, 1'b0, 8'h99);
        // R6 I/O 4 states with three wait states
        run_xfer("R6", 1'b1, 1'b1, 1'b1, 2'd2, 4'b0000, 3, 1'b0, 8'h24);
        // R7 I/O 3 states: wait ignored
        run_xfer("R7", 1'b1, 1'b0, 1'b1, 2'd1, 4'b0000, 2, 1'b0, 8'h6B);
        // R7 I/O 2 states: wait ignored
        run_xfer("R7", 1'b1, 1'b1, 1'b1, 2'd0, 4'b0000, 1, 1'b0, 8'h01);
        // R8 memory read, MREQ and RD cut early; capture on falling edge (R9)
        run_xfer("R8", 1'b0, 1'b0, 1'b1, 2'd1, 4'b0110, 0, 1'b0, 8'hE7);
        // R8 I/O read, only IORQ cut; RD ends on rising edge
        run_xfer("R8", 1'b1, 1'b0, 1'b1, 2'd2, 4'b1000, 1, 1'b0, 8'h42);
        // R8 memory write, only WR cut, in fixed mode; data held (R9)
        run_xfer("R8", 1'b0, 1'b1, 1'b0, 2'd1, 4'b0001, 0, 1'b0, 8'hF0);
        // R10 start during a busy transfer ignored; R11 port selection
        run_xfer("R10", 1'b0, 1'b0, 1'b1, 2'd2, 4'b0000, 0, 1'b1, 8'h81);
        run_xfer("R11", 1'b1, 1'b1, 1'b1, 2'd1, 4'b0000, 0, 1'b1, 8'h18);
        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule